// File: doc/BRIEF.md
# UART host register bank

This block is the byte-wide front end that host software uses to drive a PC-style serial port. It holds a 16-entry receive FIFO, a 16-entry transmit FIFO, a line control register, an interrupt enable register and a 16-bit baud divisor. It also produces the baud tick, which runs at 16 times the bit rate. The two lowest offsets are banked. While the divisor-latch access bit in the line control register is clear, offset 0 is the data port and offset 1 holds the interrupt enables. While that bit is set, the same two offsets reach the low and high bytes of the divisor.

The serial shifters are not part of this block. The transmitter sees the head of the transmit FIFO through a valid/data pair and removes a byte with a one-cycle pop strobe. The receiver delivers each byte with a one-cycle push strobe. Reads are combinational. A read of the data port consumes the byte it returns at the clock edge that ends the read cycle. Software polls the line status register to see whether received data is waiting and whether the transmit side has drained.

Top module: `uart_regbank`

## Requirements
- R1: With the divisor-latch access bit (bit 7 of the line control register at offset 3) clear, a read of offset 0 returns the oldest unread received byte and removes it at that clock edge. If the receive FIFO is empty, the read returns 00h and leaves the FIFO unchanged.
- R2: Line status (offset 5) bit 0 is 1 while the receive FIFO holds at least one byte. It falls to 0 in the cycle after the last byte is read.
- R3: With the access bit clear, a write to offset 0 appends the byte to the transmit FIFO. The transmitter side sees the bytes in write order on tx_data, with tx_valid high, and each tx_pop removes the head.
- R4: Line status bit 5 is 1 exactly when the transmit FIFO is empty. Line status bit 6 is 1 exactly when the transmit FIFO is empty and tx_busy is low.
- R5: With the access bit set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. These accesses do not touch either FIFO. With the access bit clear, offset 1 reads and writes the 8-bit interrupt enable register.
- R6: After reset, the interrupt enable register, line control register and divisor are all 00h, and line status reads 60h. Unmapped offsets read 00h.
- R7: With a nonzero divisor N, baud_tick is high for one cycle out of every N, and the first pulse comes N cycles after the most recent write to either divisor byte. With a divisor of 0, baud_tick stays low.
- R8: Both FIFOs hold 16 bytes. A data-port write while the transmit FIFO holds 16 bytes is dropped, and the 16 stored bytes stay intact and in order.
- R9: An rx_push while the receive FIFO holds 16 bytes is dropped and sets line status bit 1. That bit stays set until a read of line status, and it is clear in the cycle after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access; data-port reads pop |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_data | output | 8 | Head byte of the transmit FIFO |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_busy | input | 1 | Transmit shifter is still sending |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_data | input | 8 | Byte delivered by the receive shifter |
| baud_tick | output | 1 | One-cycle pulse at 16 times the bit rate |

## Verification
If a FIFO pointer or level is wrong inside the block, the port shows it in the next cycle. Line status bit 0, bit 5 or bit 6 would disagree with the number of bytes that were pushed and popped, or host_rdata and tx_data would give a byte out of order. If the banking were decoded wrongly, a divisor access would pop or push a FIFO, or would overwrite the interrupt enables. The bench catches that on the next comparison of the data port or of tx_valid. A baud counter that is not reloaded, or that runs with a zero divisor, moves the tick out of place. The every-cycle comparison flags that within one divisor period.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_LCR  = 3;
  localparam int OFS_LSR  = 5;
  localparam int LCR_BANK_BIT = 7;

  // line status layout: bit0 data ready, bit1 overrun, bit5 tx empty, bit6 tx idle
  function automatic logic [7:0] lsr_pack(input logic dr, input logic oe,
                                          input logic thre, input logic temt);
    logic [7:0] v;
    v    = 8'h00;
    v[0] = dr;
    v[1] = oe;
    v[5] = thre;
    v[6] = temt;
    return v;
  endfunction

  // tick when the counter has reached the last step of a nonzero divisor
  function automatic logic baud_hit(input logic [15:0] cnt, input logic [15:0] div);
    return (div != 16'd0) && (cnt == div - 16'd1);
  endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic             drop,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign drop    = push & full;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             reload,
  output logic             tick
);
  import uart_regbank_pkg::*;

  logic [DIV_W-1:0] cnt;

  assign tick = baud_hit(16'(cnt), 16'(divisor));

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt <= '0;
    else if (reload || divisor == '0)     cnt <= '0;
    else if (tick)                        cnt <= '0;
    else                                  cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int ADDR_W     = 3,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_pop,
  input  logic              tx_busy,
  input  logic              rx_push,
  input  logic [7:0]        rx_data,
  output logic              baud_tick
);
  import uart_regbank_pkg::*;

  logic [7:0]  lcr_q, ier_q, dll_q, dlm_q;
  logic        ovr_flag;
  logic        dlab;
  logic        sel_data, sel_ier, sel_lcr, sel_lsr;
  logic        rx_pop_req, tx_push_req, div_wr, lsr_rd;
  logic        rx_empty, rx_full, rx_drop;
  logic        tx_empty, tx_full, tx_drop;
  logic [7:0]  rx_head;
  logic [LVL_W-1:0] rx_level, tx_level;
  logic [15:0] divisor;
  logic        thre, temt;

  assign dlab     = lcr_q[LCR_BANK_BIT];
  assign sel_data = (host_addr == ADDR_W'(OFS_DATA));
  assign sel_ier  = (host_addr == ADDR_W'(OFS_IER));
  assign sel_lcr  = (host_addr == ADDR_W'(OFS_LCR));
  assign sel_lsr  = (host_addr == ADDR_W'(OFS_LSR));

  // named access events
  assign rx_pop_req  = host_rd & sel_data & ~dlab;
  assign tx_push_req = host_wr & sel_data & ~dlab;
  assign div_wr      = host_wr & dlab & (sel_data | sel_ier);
  assign lsr_rd      = host_rd & sel_lsr;

  assign divisor = {dlm_q, dll_q};
  assign thre    = tx_empty;
  assign temt    = tx_empty & ~tx_busy;

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata (rx_data),
    .pop   (rx_pop_req),
    .head  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .drop  (rx_drop),
    .level (rx_level)
  );

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push_req),
    .wdata (host_wdata),
    .pop   (tx_pop),
    .head  (tx_data),
    .empty (tx_empty),
    .full  (tx_full),
    .drop  (tx_drop),
    .level (tx_level)
  );

  assign tx_valid = ~tx_empty;

  uart_baud_gen #(.DIV_W(16)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .reload  (div_wr),
    .tick    (baud_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q <= 8'h00;
      ier_q <= 8'h00;
      dll_q <= 8'h00;
      dlm_q <= 8'h00;
    end else if (host_wr) begin
      if (sel_lcr)                 lcr_q <= host_wdata;
      if (sel_ier && !dlab)        ier_q <= host_wdata;
      if (sel_ier && dlab)         dlm_q <= host_wdata;
      if (sel_data && dlab)        dll_q <= host_wdata;
    end
  end

  // sticky overrun: a new drop wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) ovr_flag <= 1'b0;
    else        ovr_flag <= (ovr_flag & ~lsr_rd) | rx_drop;
  end

  always_comb begin
    host_rdata = 8'h00;
    if (sel_data)     host_rdata = dlab ? dll_q : (rx_empty ? 8'h00 : rx_head);
    else if (sel_ier) host_rdata = dlab ? dlm_q : ier_q;
    else if (sel_lcr) host_rdata = lcr_q;
    else if (sel_lsr) host_rdata = lsr_pack(~rx_empty, ovr_flag, thre, temt);
  end

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int ADDR_W     = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              baud_tick,
  input logic              dlab,
  input logic              rx_empty,
  input logic              rx_full,
  input logic              tx_full,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  tx_level,
  input logic              ovr_flag,
  input logic              thre,
  input logic              temt,
  input logic [15:0]       divisor
);

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(0) && !dlab && rx_empty) |-> host_rdata == 8'h00); // R1

  AST_LAST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(0) && !dlab && rx_level == LVL_W'(1) && !rx_push) |=> rx_empty); // R2

  AST_TX_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(0) && !dlab && !tx_full && !tx_pop) |=> tx_level == $past(tx_level) + LVL_W'(1)); // R3

  AST_IDLE_IMPLIES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> thre); // R4

  AST_BANKED_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(0) && dlab && !rx_push) |=> $stable(rx_level)); // R5

  AST_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 16'd0) |-> !baud_tick); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(FIFO_DEPTH)) && (rx_level <= LVL_W'(FIFO_DEPTH))); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovr_flag); // R9

  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(5) && !(rx_push && rx_full)) |=> !ovr_flag); // R9

endmodule

bind uart_regbank uart_regbank_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (.*);

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_pop = 1'b0, tx_busy = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       baud_tick;

  int checks = 0, failures = 0;
  bit done = 0;
  int tick_cnt = 0;

  always #2.5 clk = ~clk;

  uart_regbank i_uart_regbank (.*);

  // ---------------- reference model ----------------
  logic [7:0] m_rxq[$];
  logic [7:0] m_txq[$];
  logic [7:0] m_lcr, m_ier, m_dll, m_dlm;
  bit         m_ovr;
  int         m_since;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxq.delete(); m_txq.delete();
      m_lcr = 0; m_ier = 0; m_dll = 0; m_dlm = 0; m_ovr = 0; m_since = 0;
    end else begin
      bit bank, rx_room, tx_room, reload;
      bank    = m_lcr[7];
      rx_room = m_rxq.size() < 16;
      tx_room = m_txq.size() < 16;
      reload  = host_wr && bank && (host_addr == 0 || host_addr == 1);
      if (host_rd && host_addr == 0 && !bank && m_rxq.size() > 0) void'(m_rxq.pop_front());
      if (tx_pop && m_txq.size() > 0) void'(m_txq.pop_front());
      if (host_rd && host_addr == 5) m_ovr = 0;
      if (rx_push) begin
        if (rx_room) m_rxq.push_back(rx_data);
        else m_ovr = 1;
      end
      if (host_wr) begin
        if (host_addr == 0 && bank) m_dll = host_wdata;
        if (host_addr == 0 && !bank && tx_room) m_txq.push_back(host_wdata);
        if (host_addr == 1 && bank) m_dlm = host_wdata;
        if (host_addr == 1 && !bank) m_ier = host_wdata;
        if (host_addr == 3) m_lcr = host_wdata;
      end
      m_since = reload ? 0 : m_since + 1;
    end
  end

  function automatic logic [7:0] exp_rdata();
    logic [7:0] v;
    v = 8'h00;
    case (host_addr)
      3'd0: v = m_lcr[7] ? m_dll : (m_rxq.size() > 0 ? m_rxq[0] : 8'h00);
      3'd1: v = m_lcr[7] ? m_dlm : m_ier;
      3'd3: v = m_lcr;
      3'd5: begin
        v[0] = m_rxq.size() > 0;
        v[1] = m_ovr;
        v[5] = m_txq.size() == 0;
        v[6] = (m_txq.size() == 0) && !tx_busy;
      end
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic bit exp_tick();
    int d;
    d = {m_dlm, m_dll};
    return (d != 0) && ((m_since % d) == d - 1);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      if (host_addr == 0 && !m_lcr[7]) tag = "R1";
      else if (host_addr <= 1)         tag = "R5";
      else if (host_addr == 5)         tag = "R4";
      else                             tag = "R6";
      chk(tag, host_rdata, exp_rdata());
      chk("R3", {7'd0, tx_valid}, {7'd0, m_txq.size() > 0});
      if (m_txq.size() > 0) chk("R3", tx_data, m_txq[0]);
      chk("R7", {7'd0, baud_tick}, {7'd0, exp_tick()});
      if (baud_tick) tick_cnt++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    host_addr = a; host_wdata = d; host_wr = 1;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic rx_in(input logic [7:0] d);
    @(negedge clk); #1;
    rx_push = 1; rx_data = d;
    @(posedge clk); #1;
    rx_push = 0;
  endtask

  task automatic tx_take();
    @(negedge clk); #1;
    tx_pop = 1;
    @(posedge clk); #1;
    tx_pop = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] r;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle(1);

    // R6: reset values
    bus_rd(3'd5, r); chk("R6", r, 8'h60);
    bus_rd(3'd1, r); chk("R6", r, 8'h00);
    bus_rd(3'd3, r); chk("R6", r, 8'h00);
    bus_rd(3'd7, r); chk("R6", r, 8'h00);
    tick_cnt = 0; idle(20); chk("R7", 8'(tick_cnt), 8'd0);

    // R5: banked divisor access, 9600 bps setting
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd0, 8'h0C);
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd0, r); chk("R5", r, 8'h0C);
    bus_rd(3'd1, r); chk("R5", r, 8'h00);
    chk("R5", {7'd0, tx_valid}, 8'd0);
    tick_cnt = 0; idle(48); chk("R7", 8'(tick_cnt), 8'd4);
    bus_wr(3'd0, 8'h01);
    tick_cnt = 0; idle(10); chk("R7", 8'(tick_cnt), 8'd10);
    bus_wr(3'd0, 8'h00);
    tick_cnt = 0; idle(30); chk("R7", 8'(tick_cnt), 8'd0);
    bus_wr(3'd0, 8'h03);
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd1, 8'hA5);
    bus_rd(3'd1, r); chk("R5", r, 8'hA5);
    bus_wr(3'd3, 8'h83);
    bus_rd(3'd0, r); chk("R5", r, 8'h03);
    bus_rd(3'd1, r); chk("R5", r, 8'h00);
    bus_wr(3'd3, 8'h03);

    // R3 / R4: transmit path
    bus_wr(3'd0, 8'h11);
    bus_wr(3'd0, 8'h22);
    bus_wr(3'd0, 8'h33);
    tx_busy = 1;
    bus_rd(3'd5, r); chk("R4", r, 8'h00);
    chk("R3", tx_data, 8'h11);
    tx_take(); chk("R3", tx_data, 8'h22);
    tx_take(); tx_take();
    bus_rd(3'd5, r); chk("R4", r, 8'h20);
    tx_busy = 0; #1;
    bus_rd(3'd5, r); chk("R4", r, 8'h60);

    // R8: transmit overflow
    for (int i = 0; i < 17; i++) bus_wr(3'd0, 8'(8'h40 + i));
    for (int i = 0; i < 16; i++) begin
      chk("R8", tx_data, 8'(8'h40 + i));
      tx_take();
    end
    chk("R8", {7'd0, tx_valid}, 8'd0);

    // R1 / R2: receive path
    rx_in(8'hC1); rx_in(8'hC2); rx_in(8'hC3);
    bus_rd(3'd5, r); chk("R2", r & 8'h01, 8'h01);
    bus_rd(3'd0, r); chk("R1", r, 8'hC1);
    bus_rd(3'd0, r); chk("R1", r, 8'hC2);
    bus_rd(3'd0, r); chk("R1", r, 8'hC3);
    bus_rd(3'd5, r); chk("R2", r & 8'h01, 8'h00);
    bus_rd(3'd0, r); chk("R1", r, 8'h00);
    rx_in(8'h5A);
    bus_rd(3'd0, r); chk("R1", r, 8'h5A);

    // R9: receive overrun
    for (int i = 0; i < 17; i++) rx_in(8'(8'h80 + i));
    bus_rd(3'd5, r); chk("R9", r & 8'h03, 8'h03);
    bus_rd(3'd5, r); chk("R9", r & 8'h03, 8'h01);
    for (int i = 0; i < 16; i++) begin
      bus_rd(3'd0, r); chk("R9", r, 8'(8'h80 + i));
    end
    bus_rd(3'd5, r); chk("R9", r, 8'h60);

    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule